// File: doc/BRIEF.md
# USB 2.0 PHY Power-Up Sequencer with Use Counting

This block is a hardware state machine that brings a USB 2.0 PHY out of standby on the first request from any of its users, and powers it down again when the last user lets go. It talks to the PHY register space as a simple bus master. It presents one read or one write at a time, with an address and write data, and holds that operation until the slave returns ready. Board options such as port mode, overcurrent pin selection and polarity, and the presence of the optional signal-quality bank arrive as static configuration inputs.

The first request runs the full bring-up. It enables the PHY, then starts its PLL, optionally programs the signal-quality pair, and then polls the status word on a fixed microsecond interval until it reads the exact ready pattern. After that it releases the PHY reset, writes the packed port control word and clears both bus-alignment registers. Later init requests only increment the use count. Shutdown requests only decrement it, except the one that takes the count from one to zero, which writes zero to the PHY control register. A poll that never sees the ready pattern ends the sequence with an error, and the user is still counted.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `busWr` and `busRd` are all low, and no bus operation is presented while `busy` is low.
- R2: A bus operation keeps its direction, address and write data unchanged until the edge where `busReady` is high, and `busWr` and `busRd` are never high together.
- R3: An init taken while the use count is zero issues, in order: write 0x1 to 0x04, write 0x3 to 0x04, the optional pair of R4, the status poll of R5, write 0x7 to 0x04, the port word of R7 to 0x00, write 0x0 to 0x0C, and write 0x0 to 0x1C.
- R4: When `cfgSqBank` is high, the sequence writes 0x24 then 0x28 after the PLL write. The values are 0x41 and 0x0D when `cfgFerrite` is high, and 0x00 and 0x07 when it is low. When `cfgSqBank` is low, neither write is issued.
- R5: Each status read of address 0x08 follows an idle wait of POLL_US*CLK_PER_US cycles. Only a read value of exactly 0xC000_0000 ends the poll; any other value, including one with only an extra bit set, counts as a miss.
- R6: After MAX_POLLS reads that all miss, the sequence stops with `err` high at `done`. It does not write 0x04 with 0x7, 0x00, 0x0C or 0x1C, and the use count is still incremented.
- R7: The port word has bit 0 = `cfgPort1Func` and bit 4 = `cfgPencHigh`. Bits 8, 9 and 10 carry `cfgOvcSel[0..2]`. The polarity flags `cfgOvcActHigh[0]`, `[1]` and `[2]` go to bits 3, 1 and 6. All other bits are zero.
- R8: An init taken while the use count is non-zero issues no bus operation and raises `done` on the cycle after it is taken, with `err` low.
- R9: A shutdown that takes the count from 1 to 0 issues exactly one write, 0x0 to 0x04. A shutdown that leaves the count above zero issues no bus operation.
- R10: A shutdown taken while the count is zero issues no bus operation, still completes with `done`, and leaves the count at zero, so the next init runs the full sequence.
- R11: While `busy` is high, `initReq` and `shutReq` are ignored. Every taken request ends with a one-cycle `done` pulse, and `busy` is low on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| initReq | input | 1 | Init request pulse from a user |
| shutReq | input | 1 | Shutdown request pulse from a user |
| cfgSqBank | input | 1 | Signal-quality register pair is present |
| cfgFerrite | input | 1 | Board has a ferrite bead; selects signal-quality values |
| cfgPort1Func | input | 1 | Port 1 runs in function mode |
| cfgPencHigh | input | 1 | Drive level for the power-enable pin in function mode |
| cfgOvcSel | input | 3 | Overcurrent pin selection, one bit per port |
| cfgOvcActHigh | input | 3 | Overcurrent active-high polarity, one bit per port |
| busAddr | output | ADDR_W | Register byte address |
| busWdata | output | DATA_W | Write data |
| busWr | output | 1 | Write operation request |
| busRd | output | 1 | Read operation request |
| busRdata | input | DATA_W | Read data, valid with busReady |
| busReady | input | 1 | Slave completes the presented operation at this edge |
| busy | output | 1 | Sequencer is handling a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status of the last completed request (poll timeout) |

## Verification
On every cycle the assertions check the bus handshake: operations are held stable until ready, reads and writes are never mixed, and nothing is presented while idle. They also check that `done` is a single pulse that returns the block to idle, that the reset-release write never comes before a read of the exact ready pattern, and that a sequence never exceeds the poll limit. Only the bench scenarios can show the order and values of the writes for each board option, the poll spacing, and the reads-then-stop behaviour of a timeout. The same holds for the use-count arithmetic across nested init and shutdown requests, including the ignored shutdown at zero and requests dropped while busy.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  localparam int REG_PORT  = 'h00;
  localparam int REG_PCTL  = 'h04;
  localparam int REG_STAT  = 'h08;
  localparam int REG_ALGN0 = 'h0C;
  localparam int REG_ALGN1 = 'h1C;
  localparam int REG_SQ1   = 'h24;
  localparam int REG_SQ2   = 'h28;

  localparam logic [31:0] STAT_READY = 32'hC000_0000;

  // polarity flag positions for ports 0,1,2 (not contiguous)
  localparam int ACT_POS [3] = '{3, 1, 6};
  localparam int SEL_BASE = 8;

  typedef enum logic [3:0] {
    OP_NONE, OP_EN, OP_PLL, OP_SQ1, OP_SQ2, OP_STAT,
    OP_RST, OP_PORT, OP_ALGN0, OP_ALGN1, OP_OFF
  } busOp_e;

  typedef struct packed {
    busOp_e op;
    logic   cntUp;
    logic   cntDown;
    logic   tickRun;
    logic   pollClr;
    logic   pollStep;
  } seqCtl_t;

endpackage

// File: rtl/physeq_dp.sv
module physeq_dp
  import physeq_pkg::*;
#(
  parameter int CLK_PER_US = 8,
  parameter int POLL_US    = 10,
  parameter int MAX_POLLS  = 1024,
  parameter int COUNT_W    = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              cfgFerrite,
  input  logic              cfgPort1Func,
  input  logic              cfgPencHigh,
  input  logic [2:0]        cfgOvcSel,
  input  logic [2:0]        cfgOvcActHigh,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWr,
  output logic              busRd,
  output logic              cntZero,
  output logic              cntOne,
  output logic              tickDone,
  output logic              pollLast,
  output logic              statOk
);

  localparam int TICK_CYC = CLK_PER_US * POLL_US;
  localparam int TICK_W   = $clog2(TICK_CYC + 1);
  localparam int POLL_W   = $clog2(MAX_POLLS + 1);

  logic [COUNT_W-1:0] useCnt;
  logic [TICK_W-1:0]  tickCnt;
  logic [POLL_W-1:0]  pollCnt;
  logic [DATA_W-1:0]  portWord;
  logic               cntFull;

  assign cntZero  = (useCnt == '0);
  assign cntOne   = (useCnt == COUNT_W'(1));
  assign cntFull  = (useCnt == '1);
  assign tickDone = (tickCnt == TICK_W'(TICK_CYC - 1));
  assign pollLast = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign statOk   = (busRdata == DATA_W'(STAT_READY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useCnt  <= '0;
      tickCnt <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.cntUp && !cntFull)          useCnt <= useCnt + 1'b1;
      else if (ctl.cntDown && !cntZero)   useCnt <= useCnt - 1'b1;
      tickCnt <= ctl.tickRun ? tickCnt + 1'b1 : '0;
      if (ctl.pollClr)                    pollCnt <= '0;
      else if (ctl.pollStep)              pollCnt <= pollCnt + 1'b1;
    end
  end

  always_comb begin
    portWord    = '0;
    portWord[0] = cfgPort1Func;
    portWord[4] = cfgPencHigh;
    for (int p = 0; p < 3; p++) begin
      portWord[SEL_BASE + p] = cfgOvcSel[p];
      portWord[ACT_POS[p]]   = cfgOvcActHigh[p];
    end
  end

  always_comb begin
    busAddr  = '0;
    busWdata = '0;
    busWr    = 1'b0;
    busRd    = 1'b0;
    unique case (ctl.op)
      OP_EN:    begin busWr = 1'b1; busAddr = ADDR_W'(REG_PCTL); busWdata = DATA_W'(1); end
      OP_PLL:   begin busWr = 1'b1; busAddr = ADDR_W'(REG_PCTL); busWdata = DATA_W'(3); end
      OP_SQ1:   begin busWr = 1'b1; busAddr = ADDR_W'(REG_SQ1);
                      busWdata = cfgFerrite ? DATA_W'('h41) : '0; end
      OP_SQ2:   begin busWr = 1'b1; busAddr = ADDR_W'(REG_SQ2);
                      busWdata = cfgFerrite ? DATA_W'('h0D) : DATA_W'('h07); end
      OP_STAT:  begin busRd = 1'b1; busAddr = ADDR_W'(REG_STAT); end
      OP_RST:   begin busWr = 1'b1; busAddr = ADDR_W'(REG_PCTL); busWdata = DATA_W'(7); end
      OP_PORT:  begin busWr = 1'b1; busAddr = ADDR_W'(REG_PORT); busWdata = portWord; end
      OP_ALGN0: begin busWr = 1'b1; busAddr = ADDR_W'(REG_ALGN0); end
      OP_ALGN1: begin busWr = 1'b1; busAddr = ADDR_W'(REG_ALGN1); end
      OP_OFF:   begin busWr = 1'b1; busAddr = ADDR_W'(REG_PCTL); end
      default:  ;
    endcase
  end

endmodule

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
  import physeq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    initReq,
  input  logic    shutReq,
  input  logic    cfgSqBank,
  input  logic    busReady,
  input  logic    cntZero,
  input  logic    cntOne,
  input  logic    tickDone,
  input  logic    pollLast,
  input  logic    statOk,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    err
);

  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_PLL, S_SQ1, S_SQ2, S_WAIT, S_POLL,
    S_RST, S_PORT, S_ALGN0, S_ALGN1, S_OFF, S_FIN
  } state_e;

  state_e state, stateNext;
  logic   errQ;
  logic   timeout;

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign err     = errQ;
  assign timeout = (state == S_POLL) && busReady && !statOk && pollLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && (initReq || shutReq)) errQ <= 1'b0;
      else if (timeout)                             errQ <= 1'b1;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.op    = OP_NONE;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        ctl.pollClr = 1'b1;
        if (initReq) begin
          ctl.cntUp = 1'b1;
          stateNext = cntZero ? S_EN : S_FIN;
        end else if (shutReq) begin
          ctl.cntDown = 1'b1;
          stateNext   = cntOne ? S_OFF : S_FIN;
        end
      end
      S_EN:    begin ctl.op = OP_EN;  if (busReady) stateNext = S_PLL; end
      S_PLL:   begin ctl.op = OP_PLL; if (busReady) stateNext = cfgSqBank ? S_SQ1 : S_WAIT; end
      S_SQ1:   begin ctl.op = OP_SQ1; if (busReady) stateNext = S_SQ2; end
      S_SQ2:   begin ctl.op = OP_SQ2; if (busReady) stateNext = S_WAIT; end
      S_WAIT:  begin ctl.tickRun = 1'b1; if (tickDone) stateNext = S_POLL; end
      S_POLL: begin
        ctl.op = OP_STAT;
        if (busReady) begin
          if (statOk)        stateNext = S_RST;
          else if (pollLast) stateNext = S_FIN;
          else begin
            ctl.pollStep = 1'b1;
            stateNext    = S_WAIT;
          end
        end
      end
      S_RST:   begin ctl.op = OP_RST;   if (busReady) stateNext = S_PORT; end
      S_PORT:  begin ctl.op = OP_PORT;  if (busReady) stateNext = S_ALGN0; end
      S_ALGN0: begin ctl.op = OP_ALGN0; if (busReady) stateNext = S_ALGN1; end
      S_ALGN1: begin ctl.op = OP_ALGN1; if (busReady) stateNext = S_FIN; end
      S_OFF:   begin ctl.op = OP_OFF;   if (busReady) stateNext = S_FIN; end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import physeq_pkg::*;
#(
  parameter int CLK_PER_US = 8,
  parameter int POLL_US    = 10,
  parameter int MAX_POLLS  = 1024,
  parameter int COUNT_W    = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              shutReq,
  input  logic              cfgSqBank,
  input  logic              cfgFerrite,
  input  logic              cfgPort1Func,
  input  logic              cfgPencHigh,
  input  logic [2:0]        cfgOvcSel,
  input  logic [2:0]        cfgOvcActHigh,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWr,
  output logic              busRd,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              busy,
  output logic              done,
  output logic              err
);

  seqCtl_t ctl;
  logic cntZero, cntOne, tickDone, pollLast, statOk;

  physeq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .shutReq(shutReq),
    .cfgSqBank(cfgSqBank), .busReady(busReady), .cntZero(cntZero),
    .cntOne(cntOne), .tickDone(tickDone), .pollLast(pollLast),
    .statOk(statOk), .ctl(ctl), .busy(busy), .done(done), .err(err)
  );

  physeq_dp #(
    .CLK_PER_US(CLK_PER_US), .POLL_US(POLL_US), .MAX_POLLS(MAX_POLLS),
    .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgFerrite(cfgFerrite),
    .cfgPort1Func(cfgPort1Func), .cfgPencHigh(cfgPencHigh),
    .cfgOvcSel(cfgOvcSel), .cfgOvcActHigh(cfgOvcActHigh),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .cntZero(cntZero), .cntOne(cntOne),
    .tickDone(tickDone), .pollLast(pollLast), .statOk(statOk)
  );

endmodule

// File: rtl/physeq_chk.sv
module physeq_chk #(
  parameter int MAX_POLLS = 1024,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdata,
  input logic              busReady,
  input logic              busy,
  input logic              done
);

  localparam int CW = $clog2(MAX_POLLS + 2);

  logic [CW-1:0] readsSeen;
  logic          lockSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readsSeen <= '0;
      lockSeen  <= 1'b0;
    end else if (!busy) begin
      readsSeen <= '0;
      lockSeen  <= 1'b0;
    end else if (busRd && busReady) begin
      readsSeen <= readsSeen + 1'b1;
      if (busRdata == DATA_W'(32'hC000_0000)) lockSeen <= 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWr && !busRd));

  a_r2_one_dir: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((busWr || busRd) && !busReady) |=>
      (busWr == $past(busWr)) && (busRd == $past(busRd)) &&
      $stable(busAddr) && $stable(busWdata));

  a_r5_release_after_lock: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'('h04) && busWdata == DATA_W'(7)) |-> lockSeen);

  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (readsSeen <= CW'(MAX_POLLS)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind phy_bringup_seq physeq_chk #(
  .MAX_POLLS(MAX_POLLS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
  .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .busReady(busReady),
  .busy(busy), .done(done)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 1;
  localparam int POLL_US    = 10;
  localparam int TICK       = CPU * POLL_US;
  localparam int MAXP       = 1024;

  // {bank, ferrite, func, penc, sel[2:0], act[2:0], good[7:0], lat[1:0], port[15:0]}
  localparam logic [35:0] VEC [4] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 3'b101, 3'b011, 8'd0, 2'd0, 16'h050B},
    {1'b1, 1'b0, 1'b0, 1'b1, 3'b010, 3'b100, 8'd3, 2'd2, 16'h0250},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'b111, 3'b111, 8'd1, 2'd1, 16'h075B},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'd5, 2'd3, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initReq = 1'b0, shutReq = 1'b0;
  logic        cfgSqBank = 1'b0, cfgFerrite = 1'b0, cfgPort1Func = 1'b0, cfgPencHigh = 1'b0;
  logic [2:0]  cfgOvcSel = '0, cfgOvcActHigh = '0;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic        busWr, busRd;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic        busy, done, err;

  int nChk = 0, nErr = 0;
  int cyc = 0;
  int lat = 0, goodAfter = 0, waitCnt = 0;
  logic [31:0] badVal = 32'hC000_0001;
  int nLog = 0, nRd = 0, firstRdPos = -1, lastRdPos = -1, lastRdCyc = 0;
  int gapBad = 0, holdBad = 0;
  logic [7:0]  lAddr [64];
  logic [31:0] lData [64];
  logic [7:0]  hAddr;
  logic [31:0] hData;
  logic        hWr;
  int          expN;
  logic [7:0]  eAddr [16];
  logic [31:0] eData [16];
  int          reqCycles;
  logic        reqErr;

  phy_bringup_seq #(.CLK_PER_US(CPU), .POLL_US(POLL_US), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .shutReq(shutReq),
    .cfgSqBank(cfgSqBank), .cfgFerrite(cfgFerrite), .cfgPort1Func(cfgPort1Func),
    .cfgPencHigh(cfgPencHigh), .cfgOvcSel(cfgOvcSel), .cfgOvcActHigh(cfgOvcActHigh),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .busReady(busReady), .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // register slave model, acts on the falling edge
  always @(negedge clk) begin
    if (busReady) begin
      busReady = 1'b0;
      waitCnt  = 0;
    end else if (busWr || busRd) begin
      if (busWr && busRd) holdBad++;
      if (waitCnt > 0 && (busAddr !== hAddr || busWdata !== hData || busWr !== hWr)) holdBad++;
      hAddr = busAddr; hData = busWdata; hWr = busWr;
      if (waitCnt >= lat) begin
        busReady = 1'b1;
        if (busRd) begin
          if (busAddr !== 8'h08) gapBad++;
          if (nRd > 0 && (cyc - lastRdCyc) != TICK + lat + 1) gapBad++;
          if (nRd == 0) firstRdPos = nLog;
          lastRdPos = nLog;
          lastRdCyc = cyc;
          busRdata  = (nRd >= goodAfter) ? 32'hC000_0000 : badVal;
          nRd++;
        end else begin
          if (nLog < 64) begin lAddr[nLog] = busAddr; lData[nLog] = busWdata; end
          nLog++;
        end
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    nLog = 0; nRd = 0; firstRdPos = -1; lastRdPos = -1;
  endtask

  task automatic request(input bit isInit);
    @(negedge clk);
    initReq = isInit; shutReq = !isInit;
    @(negedge clk);
    initReq = 1'b0; shutReq = 1'b0;
    reqCycles = 1;
    while (!done && reqCycles < 40000) begin
      @(negedge clk);
      reqCycles++;
    end
    reqErr = err;
    checkEq("R11", "done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic pushExp(input logic [7:0] a, input logic [31:0] d);
    eAddr[expN] = a; eData[expN] = d; expN++;
  endtask

  task automatic checkFullSeq(input bit bank, input bit ferr, input logic [15:0] port,
                              input int good);
    expN = 0;
    pushExp(8'h04, 32'h1);
    pushExp(8'h04, 32'h3);
    if (bank) begin
      pushExp(8'h24, ferr ? 32'h41 : 32'h00);
      pushExp(8'h28, ferr ? 32'h0D : 32'h07);
    end
    pushExp(8'h04, 32'h7);
    pushExp(8'h00, {16'h0, port});
    pushExp(8'h0C, 32'h0);
    pushExp(8'h1C, 32'h0);
    checkEq("R3", "write count", nLog, expN);
    for (int i = 0; i < expN && i < nLog; i++) begin
      checkEq((i >= 2 && i < 4 && bank) ? "R4" : "R3", $sformatf("addr %0d", i), {24'h0, lAddr[i]}, {24'h0, eAddr[i]});
      checkEq((eAddr[i] == 8'h00) ? "R7" : (eAddr[i] >= 8'h24 ? "R4" : "R3"),
              $sformatf("data %0d", i), lData[i], eData[i]);
    end
    checkEq("R5", "status reads", nRd, good + 1);
    checkEq("R5", "poll placed after setup writes", firstRdPos, bank ? 4 : 2);
    checkEq("R5", "no write between polls", lastRdPos, bank ? 4 : 2);
    checkEq("R5", "poll spacing errors", gapBad, 0);
    checkEq("R11", "err after good init", {31'd0, reqErr}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1", "busy in reset", {31'd0, busy}, 0);
    checkEq("R1", "bus ops in reset", {30'd0, busWr, busRd}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R1", "idle after reset", {28'd0, busy, done, err, busWr | busRd}, 0);

    // table of board options: first init then last shutdown
    for (int v = 0; v < 4; v++) begin
      {cfgSqBank, cfgFerrite, cfgPort1Func, cfgPencHigh, cfgOvcSel, cfgOvcActHigh} = VEC[v][35:26];
      goodAfter = int'(VEC[v][25:18]);
      lat       = int'(VEC[v][17:16]);
      badVal    = v[0] ? 32'h8000_0000 : 32'hC000_0001;
      gapBad    = 0;
      clearLog();
      request(1'b1);
      checkFullSeq(VEC[v][35], VEC[v][34], VEC[v][15:0], goodAfter);
      clearLog();
      request(1'b0);
      checkEq("R9", "last shutdown write count", nLog, 1);
      checkEq("R9", "last shutdown addr", {24'h0, lAddr[0]}, 32'h04);
      checkEq("R9", "last shutdown data", lData[0], 32'h0);
    end

    // R6 timeout with a near-miss status value
    cfgSqBank = 1'b1; cfgFerrite = 1'b0; lat = 0; goodAfter = 100000;
    badVal = 32'hC000_0001; gapBad = 0;
    clearLog();
    request(1'b1);
    checkEq("R6", "err on timeout", {31'd0, reqErr}, 32'd1);
    checkEq("R6", "reads before giving up", nRd, MAXP);
    checkEq("R6", "writes stop before reset release", nLog, 4);
    checkEq("R5", "timeout poll spacing errors", gapBad, 0);

    // R8 second init: count was still taken by the failed one
    goodAfter = 0;
    clearLog();
    request(1'b1);
    checkEq("R8", "nested init latency", reqCycles, 1);
    checkEq("R8", "nested init bus ops", nLog + nRd, 0);
    checkEq("R8", "nested init err", {31'd0, reqErr}, 0);

    // R9 count 2 -> 1 silent, 1 -> 0 writes
    clearLog();
    request(1'b0);
    checkEq("R9", "non-last shutdown bus ops", nLog + nRd, 0);
    request(1'b0);
    checkEq("R9", "last shutdown count", nLog, 1);
    checkEq("R9", "last shutdown data", lData[0], 32'h0);

    // R10 shutdown at zero is ignored
    clearLog();
    request(1'b0);
    checkEq("R10", "shutdown at zero bus ops", nLog + nRd, 0);
    checkEq("R10", "shutdown at zero latency", reqCycles, 1);
    cfgSqBank = 1'b0; cfgFerrite = 1'b0; cfgPort1Func = 1'b0; cfgPencHigh = 1'b1;
    cfgOvcSel = 3'b001; cfgOvcActHigh = 3'b010;
    gapBad = 0;
    clearLog();
    request(1'b1);
    checkEq("R10", "init after ignored shutdown runs full", nLog, 6);
    checkFullSeq(1'b0, 1'b0, 16'h0112, 0);

    // R11 requests while busy are dropped; count stays 1
    clearLog();
    request(1'b0);
    clearLog();
    goodAfter = 2;
    @(negedge clk); initReq = 1'b1;
    @(negedge clk); initReq = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R11", "busy during sequence", {31'd0, busy}, 1);
    shutReq = 1'b1; @(negedge clk); shutReq = 1'b0;
    @(negedge clk); initReq = 1'b1; @(negedge clk); initReq = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    checkEq("R11", "done is one cycle", {30'd0, done, busy}, 0);
    clearLog();
    request(1'b0);
    checkEq("R11", "busy-time requests dropped", nLog, 1);
    clearLog();
    request(1'b0);
    checkEq("R11", "count back at zero", nLog, 0);
    checkEq("R2", "handshake hold violations", holdBad, 0);

    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

endmodule